// File: doc/BRIEF.md
# Receive character queue with level-triggered request

This block buffers characters that a serial receiver has already assembled, together with a break tag and three error tags per character. A register interface drains it through data-register reads. With queue mode on it behaves as a 16-slot circular buffer. With queue mode off it collapses to one holding slot. The mode can change at run time, and every change empties the buffer.

The block reports whether the buffer is empty or full, exposes its fill level, and tells the receiver whether another character can be taken. It keeps a receive request for the interrupt logic. A push that brings the level up to a fixed trigger level raises the request. A read that leaves the level just below the trigger drops it. The request is therefore managed by events against the trigger count, not derived from a not-empty test. Every read also copies the break and error tags of the slot read into a status register.

Top module: `rxq_buffer`

## Requirements
- R1: Effective capacity is 16 slots when `fifo_en_i` is 1 and 1 slot when it is 0. `push_ready_o` is 1 exactly while the level is below that capacity and no flush is taking place in the cycle.
- R2: Characters leave in arrival order. During a read cycle, `pop_char_o`, `pop_brk_o` and `pop_err_o` show the oldest slot combinationally, and the level drops by one at the next edge.
- R3: A push offered while `push_ready_o` is 0 is dropped. Level, contents and order are unchanged.
- R4: `empty_o` is 1 exactly when the level is 0. `full_o` is 1 exactly when the level equals the effective capacity.
- R5: A read while empty leaves the level at 0. It presents the slot at the current read position, which holds stale contents.
- R6: When a push is accepted and a non-empty read occurs in the same cycle, the level is unchanged and both positions advance.
- R7: The trigger level is 1. A push that makes the level equal to the trigger sets `rx_irq_o`. A read that leaves the level one below the trigger clears it, and this includes a read of an empty buffer. When both happen in the same cycle, the set wins.
- R8: `flush_i` sets the level and read position to 0, sets `empty_o` to 1 and `full_o` to 0, and ignores any push or read in that cycle. `rx_irq_o` and `rx_stat_o` keep their values.
- R9: A change of `fifo_en_i` relative to the previous cycle flushes the buffer in that cycle, exactly as R8 does.
- R10: From the edge after each read that is not a flush cycle, `rx_stat_o` holds {break, err[2:0]} of the slot read, with break as the MSB.
- R11: After reset the level is 0, `empty_o`=1, `full_o`=0, `rx_irq_o`=0, `rx_stat_o`=0, and queue mode counts as off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | Queue mode (1 = 16 slots, 0 = single slot) |
| flush_i | input | 1 | Synchronous flush |
| push_valid_i | input | 1 | Character offered by the receiver |
| push_char_i | input | 8 | Character offered |
| push_brk_i | input | 1 | Break tag of offered character |
| push_err_i | input | 3 | Error tags of offered character |
| push_ready_o | output | 1 | Buffer can take a character this cycle |
| pop_i | input | 1 | Data-register read |
| pop_char_o | output | 8 | Character at read position |
| pop_brk_o | output | 1 | Break tag at read position |
| pop_err_o | output | 3 | Error tags at read position |
| rx_stat_o | output | 4 | Tags captured by the last read {break, err} |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Buffer full at current capacity |
| level_o | output | 5 | Fill level |
| rx_irq_o | output | 1 | Receive request |

## Verification
The read data and `push_ready_o` respond in the same cycle as their inputs. The bench samples them one nanosecond after it drives the inputs, before the edge. Level, flags, request and status are registered and take effect at the first rising edge after the stimulus. The bench samples them two nanoseconds after that edge, after it has advanced its reference model by exactly one step for the same inputs. Mode changes and flushes are therefore judged in the cycle they are applied.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
    localparam int unsigned CHAR_W = 8;
    localparam int unsigned ERR_W  = 3;
    localparam int unsigned STAT_W = ERR_W + 1;

    typedef struct packed {
        logic              brk;
        logic [ERR_W-1:0]  err;
        logic [CHAR_W-1:0] chr;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk_i,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_addr_i,
    input  rxq_entry_t       wr_data_i,
    input  logic [PTR_W-1:0] rd_addr_i,
    output rxq_entry_t       rd_data_o
);
    rxq_entry_t slots_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            slots_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = slots_q[rd_addr_i];
endmodule

// File: rtl/rxq_ctrl.sv
`timescale 1ns/1ps
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned TRIG  = 1,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fifo_en_i,
    input  logic              flush_i,
    input  logic              push_valid_i,
    input  logic              pop_i,
    input  rxq_entry_t        head_i,
    output logic              push_ready_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_addr_o,
    output logic [PTR_W-1:0]  rd_addr_o,
    output logic [CNT_W-1:0]  level_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              irq_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              mode_q_o
);
    typedef struct packed {
        logic [PTR_W-1:0]  rd_ptr;
        logic [CNT_W-1:0]  cnt;
        logic              empty;
        logic              full;
        logic              irq;
        logic              mode;
        logic [STAT_W-1:0] stat;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [CNT_W-1:0] cap_d;
    logic [PTR_W-1:0] mask_d;
    logic             flush_now;
    logic             push_ok;
    logic             pop_ok;
    logic             pop_take;
    logic [CNT_W-1:0] cnt_after_pop;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        st_d          = st_q;
        st_d.mode     = fifo_en_i;
        cap_d         = fifo_en_i ? CNT_W'(DEPTH) : CNT_W'(1);
        mask_d        = PTR_W'(cap_d - CNT_W'(1));
        flush_now     = flush_i || (fifo_en_i != st_q.mode);
        push_ok       = push_valid_i && (st_q.cnt < cap_d) && !flush_now;
        pop_ok        = pop_i && !flush_now;
        pop_take      = pop_ok && (st_q.cnt != '0);
        cnt_after_pop = st_q.cnt - CNT_W'(pop_take);
        cnt_next      = cnt_after_pop + CNT_W'(push_ok);

        if (flush_now) begin
            st_d.cnt    = '0;
            st_d.rd_ptr = '0;
            st_d.empty  = 1'b1;
            st_d.full   = 1'b0;
        end else begin
            if (pop_ok) begin
                st_d.full = 1'b0;
                st_d.stat = {head_i.brk, head_i.err};
                if ((cnt_after_pop + CNT_W'(1)) == CNT_W'(TRIG)) begin
                    st_d.irq = 1'b0;
                end
            end
            if (pop_take) begin
                st_d.rd_ptr = (st_q.rd_ptr + PTR_W'(1)) & mask_d;
            end
            if (push_ok) begin
                st_d.empty = 1'b0;
                if (cnt_next == cap_d) begin
                    st_d.full = 1'b1;
                end
                if (cnt_next == CNT_W'(TRIG)) begin
                    st_d.irq = 1'b1;
                end
            end
            st_d.cnt = cnt_next;
            if (cnt_next == '0) begin
                st_d.empty = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_ready_o = !flush_now && (st_q.cnt < cap_d);
    assign wr_en_o      = push_ok;
    assign wr_addr_o    = (st_q.rd_ptr + st_q.cnt[PTR_W-1:0]) & mask_d;
    assign rd_addr_o    = st_q.rd_ptr;
    assign level_o      = st_q.cnt;
    assign empty_o      = st_q.empty;
    assign full_o       = st_q.full;
    assign irq_o        = st_q.irq;
    assign stat_o       = st_q.stat;
    assign mode_q_o     = st_q.mode;
endmodule

// File: rtl/rxq_buffer.sv
`timescale 1ns/1ps
module rxq_buffer
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned TRIG  = 1,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fifo_en_i,
    input  logic              flush_i,
    input  logic              push_valid_i,
    input  logic [CHAR_W-1:0] push_char_i,
    input  logic              push_brk_i,
    input  logic [ERR_W-1:0]  push_err_i,
    output logic              push_ready_o,
    input  logic              pop_i,
    output logic [CHAR_W-1:0] pop_char_o,
    output logic              pop_brk_o,
    output logic [ERR_W-1:0]  pop_err_o,
    output logic [STAT_W-1:0] rx_stat_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [CNT_W-1:0]  level_o,
    output logic              rx_irq_o
);
    rxq_entry_t       wr_entry;
    rxq_entry_t       head;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [PTR_W-1:0] rd_addr;
    logic             mode_q;

    assign wr_entry = '{brk: push_brk_i, err: push_err_i, chr: push_char_i};

    rxq_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .fifo_en_i    (fifo_en_i),
        .flush_i      (flush_i),
        .push_valid_i (push_valid_i),
        .pop_i        (pop_i),
        .head_i       (head),
        .push_ready_o (push_ready_o),
        .wr_en_o      (wr_en),
        .wr_addr_o    (wr_addr),
        .rd_addr_o    (rd_addr),
        .level_o      (level_o),
        .empty_o      (empty_o),
        .full_o       (full_o),
        .irq_o        (rx_irq_o),
        .stat_o       (rx_stat_o),
        .mode_q_o     (mode_q)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk_i     (clk_i),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_entry),
        .rd_addr_i (rd_addr),
        .rd_data_o (head)
    );

    assign pop_char_o = head.chr;
    assign pop_brk_o  = head.brk;
    assign pop_err_o  = head.err;
endmodule

// File: rtl/rxq_buffer_chk.sv
`timescale 1ns/1ps
module rxq_buffer_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned TRIG  = 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             fifo_en_i,
    input logic             flush_i,
    input logic             push_valid_i,
    input logic             push_ready_o,
    input logic             pop_i,
    input logic             empty_o,
    input logic             full_o,
    input logic [CNT_W-1:0] level_o,
    input logic             rx_irq_o,
    input logic             mode_q
);
    assert_ready_below_cap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_ready_o |-> (level_o < CNT_W'(DEPTH)));

    assert_pop_decrements_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !empty_o && !push_valid_i && !flush_i && (fifo_en_i == mode_q))
        |=> (level_o == $past(level_o) - CNT_W'(1)));

    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && push_valid_i && !pop_i && !flush_i && (fifo_en_i == mode_q))
        |=> $stable(level_o));

    assert_empty_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty_o == (level_o == '0));

    assert_full_nonempty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        full_o |-> (level_o != '0));

    assert_same_cycle_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_valid_i && push_ready_o && pop_i && !empty_o) |=> $stable(level_o));

    assert_irq_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rx_irq_o) |-> (level_o == CNT_W'(TRIG)));

    assert_irq_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rx_irq_o) |-> (level_o == CNT_W'(TRIG - 1)));

    assert_flush_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (level_o == '0 && empty_o && !full_o));

    assert_mode_change_flushes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fifo_en_i != mode_q) |=> (level_o == '0 && empty_o));
endmodule

bind rxq_buffer rxq_buffer_chk #(.DEPTH(DEPTH), .TRIG(TRIG)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_en_i    (fifo_en_i),
    .flush_i      (flush_i),
    .push_valid_i (push_valid_i),
    .push_ready_o (push_ready_o),
    .pop_i        (pop_i),
    .empty_o      (empty_o),
    .full_o       (full_o),
    .level_o      (level_o),
    .rx_irq_o     (rx_irq_o),
    .mode_q       (mode_q)
);

// File: tb/rxq_buffer_tb.sv
`timescale 1ns/1ps
module rxq_buffer_tb_top;
    localparam int TRIG = 1;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       fifo_en_i = 1'b0;
    logic       flush_i = 1'b0;
    logic       push_valid_i = 1'b0;
    logic [7:0] push_char_i = '0;
    logic       push_brk_i = 1'b0;
    logic [2:0] push_err_i = '0;
    logic       push_ready_o;
    logic       pop_i = 1'b0;
    logic [7:0] pop_char_o;
    logic       pop_brk_o;
    logic [2:0] pop_err_o;
    logic [3:0] rx_stat_o;
    logic       empty_o;
    logic       full_o;
    logic [4:0] level_o;
    logic       rx_irq_o;

    always #4 clk_i = ~clk_i;

    rxq_buffer dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i), .flush_i(flush_i),
        .push_valid_i(push_valid_i), .push_char_i(push_char_i), .push_brk_i(push_brk_i),
        .push_err_i(push_err_i), .push_ready_o(push_ready_o), .pop_i(pop_i),
        .pop_char_o(pop_char_o), .pop_brk_o(pop_brk_o), .pop_err_o(pop_err_o),
        .rx_stat_o(rx_stat_o), .empty_o(empty_o), .full_o(full_o), .level_o(level_o),
        .rx_irq_o(rx_irq_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model
    logic [11:0] m_mem [16];
    bit          m_val [16];
    int          m_cnt = 0;
    int          m_rp = 0;
    bit          m_empty = 1'b1;
    bit          m_full = 1'b0;
    bit          m_irq = 1'b0;
    bit          m_mode = 1'b0;
    logic [3:0]  m_stat = '0;
    bit          m_stat_known = 1'b1;

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int cap_of(input bit en);
        return en ? 16 : 1;
    endfunction

    task automatic step(input string tag, input bit en, input bit fl, input bit pv,
                        input logic [11:0] pd, input bit po);
        bit flushc;
        int depth;
        bit pe;
        bit pt;
        int cap;
        @(negedge clk_i);
        fifo_en_i    = en;
        flush_i      = fl;
        push_valid_i = pv;
        {push_brk_i, push_err_i, push_char_i} = pd;
        pop_i        = po;
        #1;
        flushc = fl || (en != m_mode);
        depth  = cap_of(en);
        chk("R1", "ready", push_ready_o, !flushc && (m_cnt < depth));
        if (po && !flushc && m_val[m_rp]) begin
            if (m_cnt == 0) chk("R5", "stale head", {pop_brk_o, pop_err_o, pop_char_o}, m_mem[m_rp]);
            else            chk("R2", "head", {pop_brk_o, pop_err_o, pop_char_o}, m_mem[m_rp]);
        end
        @(posedge clk_i);
        if (flushc) begin
            m_cnt = 0; m_rp = 0; m_empty = 1'b1; m_full = 1'b0;
        end else begin
            pe = pv && (m_cnt < depth);
            pt = po && (m_cnt > 0);
            if (po) begin
                m_full = 1'b0;
                m_stat_known = m_val[m_rp];
                m_stat = m_mem[m_rp][11:8];
            end
            cap = m_cnt - int'(pt);
            if (po && (cap + 1 == TRIG)) m_irq = 1'b0;
            if (pe) begin
                m_mem[(m_rp + m_cnt) & (depth - 1)] = pd;
                m_val[(m_rp + m_cnt) & (depth - 1)] = 1'b1;
                m_empty = 1'b0;
            end
            if (pt) m_rp = (m_rp + 1) & (depth - 1);
            m_cnt = cap + int'(pe);
            if (pe && m_cnt == depth) m_full = 1'b1;
            if (pe && m_cnt == TRIG) m_irq = 1'b1;
            if (m_cnt == 0) m_empty = 1'b1;
        end
        m_mode = en;
        #2;
        chk(tag, "level", level_o, m_cnt);
        chk("R4", "empty", empty_o, m_empty);
        chk("R4", "full", full_o, m_full);
        chk("R7", "irq", rx_irq_o, m_irq);
        if (m_stat_known) chk("R10", "status", rx_stat_o, m_stat);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0bad));
        for (int i = 0; i < 16; i++) m_val[i] = 1'b0;
        repeat (3) @(posedge clk_i);
        #1 rst_ni = 1'b1;
        #2;
        // R11 reset state
        chk("R11", "level", level_o, 0);
        chk("R11", "empty", empty_o, 1);
        chk("R11", "full", full_o, 0);
        chk("R11", "irq", rx_irq_o, 0);
        chk("R11", "status", rx_stat_o, 0);

        // R9 enable queue mode, then fill 16 and overflow (R1, R3)
        step("R9", 1, 0, 0, 12'h000, 0);
        for (int i = 0; i < 16; i++) step("R1", 1, 0, 1, 12'(i * 37 + 12'h900), 0);
        step("R3", 1, 0, 1, 12'h5AA, 0);
        step("R3", 1, 0, 1, 12'h4BB, 0);
        // R2 drain in order, R7 irq drops on last read
        for (int i = 0; i < 16; i++) step("R2", 1, 0, 0, 12'h000, 1);
        // R5 read of empty: stale slot, irq clear again
        step("R5", 1, 0, 0, 12'h000, 1);
        // R6 simultaneous push and pop
        for (int i = 0; i < 3; i++) step("R6", 1, 0, 1, 12'(12'h310 + i), 0);
        step("R6", 1, 0, 1, 12'hF42, 1);
        step("R6", 1, 0, 1, 12'h843, 1);
        // R8 flush keeps irq, then empty read clears it
        step("R8", 1, 1, 1, 12'h111, 1);
        step("R7", 1, 0, 0, 12'h000, 1);
        step("R7", 1, 0, 1, 12'h222, 1);
        // R9 switch to single slot, R1/R3 capacity one
        step("R9", 0, 0, 1, 12'h333, 0);
        step("R1", 0, 0, 1, 12'h744, 0);
        step("R3", 0, 0, 1, 12'h055, 0);
        step("R10", 0, 0, 0, 12'h000, 1);
        step("R10", 0, 0, 1, 12'hA66, 1);

        for (int i = 0; i < 3000; i++) begin
            bit en;
            en = (($urandom % 100) < 2) ? !m_mode : m_mode;
            step("R1", en, ($urandom % 100) < 2, ($urandom % 2) == 1,
                 12'($urandom), ($urandom % 100) < 45);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule